// File: doc/BRIEF.md
# Loss-of-Signal Zero-Run Monitor

The monitor watches a recovered unipolar receive bit stream, one bit per cycle in which the bit enable is high. It declares a loss-of-signal (LOS) condition when the run of consecutive zeros grows long enough, and it clears the condition only when the stream again looks like live traffic. The declare threshold depends on the line mode (T1 or E1). An extended-threshold option raises it to 2048 zeros in both modes.

Recovery is judged over a sliding window of the most recent bits. In T1 mode the window is 128 bits long. In E1 mode it is 32 bits long. The window must hold enough ones, and no long zero run may have been counted inside it. In E1 mode, recovery can instead require an unbroken run of 32 ones. The block has three outputs: an LOS status bit, a clock-select line that picks the master clock while LOS is asserted, and a one-cycle pulse on every LOS change for an interrupt block. Received data is not touched by this block.

Top module: `los_monitor`

## Requirements
- R1: After reset, `los` and `use_master_clk` are 1 and `los_change` is 0. All run counters and the bit history are cleared, and the history counts as empty.
- R2: The zero run count rises by one on each accepted 0 and returns to 0 on each accepted 1. With `e1_mode`=0 and `long_declare`=0, LOS is set on the accepted bit that brings the count to 175. At 174 it stays clear.
- R3: With `e1_mode`=1 and `long_declare`=0, LOS is set on the accepted bit that brings the zero run count to 32. At 31 it stays clear.
- R4: With `long_declare`=1, the declare threshold is 2048 zeros in both modes.
- R5: With `e1_mode`=0, LOS clears on an accepted bit after which both hold: the last 128 accepted bits hold at least 16 ones, and the zero run count stayed below 100 at each of those 128 bits. At least 128 bits must have been accepted since reset.
- R6: With `e1_mode`=1 and `mark_clear`=0, LOS clears on an accepted bit after which both hold: the last 32 accepted bits hold at least 4 ones, and the zero run count stayed below 16 at each of those 32 bits. At least 32 bits must have been accepted since reset.
- R7: With `e1_mode`=1 and `mark_clear`=1, LOS clears only on the accepted bit that completes 32 consecutive ones, whatever the window density. With `e1_mode`=0, `mark_clear` has no effect.
- R8: `use_master_clk` equals `los` in every cycle (1 selects the master clock).
- R9: `los` changes at the clock edge that accepts the deciding bit. `los_change` is 1 for exactly the cycle that follows each change of `los`, and 0 at all other times.
- R10: A cycle with `bit_en`=0 changes no count, no history and no output, whatever `rx_bit` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Accept `rx_bit` this cycle |
| rx_bit | input | 1 | Recovered unipolar data bit |
| e1_mode | input | 1 | 1 = E1 thresholds and window, 0 = T1 |
| long_declare | input | 1 | 1 = declare after 2048 zeros |
| mark_clear | input | 1 | E1 only: clear on 32 consecutive ones |
| los | output | 1 | Loss-of-signal status |
| use_master_clk | output | 1 | 1 = master clock selected, 0 = recovered clock |
| los_change | output | 1 | One-cycle pulse after each LOS change |

## Verification
A wrong zero-run count shows as an LOS declaration that comes one or more bits early or late, on the exact bit of the 175, 32 or 2048 boundary. A wrong window count or a wrong zero-run history shows as an early or late clear. This can stay hidden for up to a full window of 128 bits after the fault, until a clear decision depends on the corrupted entry. A broken change pulse or clock select is visible on the very next cycle after an LOS change.

// File: rtl/los_pkg.sv
package los_pkg;
  typedef enum logic {
    ST_SIGNAL = 1'b0,
    ST_LOST   = 1'b1
  } los_state_e;
endpackage

// File: rtl/los_rst_sync.sv
module los_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/los_run_counter.sv
module los_run_counter #(
  parameter int ZERO_MAX = 2048,
  parameter int ONES_MAX = 32,
  parameter int ZW       = $clog2(ZERO_MAX + 1),
  parameter int OW       = $clog2(ONES_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          rx_bit,
  output logic [ZW-1:0] zero_nxt,
  output logic [OW-1:0] ones_nxt
);
  logic [ZW-1:0] zero_q;
  logic [OW-1:0] ones_q;

  // Saturating run counts, as they would be after the current bit
  always_comb begin
    if (rx_bit)                      zero_nxt = '0;
    else if (zero_q == ZW'(ZERO_MAX)) zero_nxt = zero_q;
    else                             zero_nxt = zero_q + 1'b1;

    if (!rx_bit)                     ones_nxt = '0;
    else if (ones_q == OW'(ONES_MAX)) ones_nxt = ones_q;
    else                             ones_nxt = ones_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= '0;
      ones_q <= '0;
    end else if (bit_en) begin
      zero_q <= zero_nxt;
      ones_q <= ones_nxt;
    end
  end

  // R2: an accepted one ends the zero run and starts a ones run
  p_one_ends_zero_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_en) && $past(rx_bit)) |-> (zero_q == '0 && ones_q != '0));

  // R10: idle cycles leave both run counts untouched
  p_idle_counts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> ($stable(zero_q) && $stable(ones_q)));
endmodule

// File: rtl/los_density_win.sv
module los_density_win #(
  parameter int WIN        = 128,
  parameter int MIN_ONES   = 16,
  parameter int ZRUN_LIMIT = 100,
  parameter int ZW         = 12,
  parameter int CW         = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          rx_bit,
  input  logic [ZW-1:0] zero_nxt,
  output logic          ok_nxt
);
  logic [WIN-1:0] hist_q, hist_nxt;
  logic [CW-1:0]  ones_q, ones_nxt;
  logic [CW-1:0]  quiet_q, quiet_nxt;

  always_comb begin
    hist_nxt = {hist_q[WIN-2:0], rx_bit};
    ones_nxt = ones_q + CW'(rx_bit) - CW'(hist_q[WIN-1]);
    // bits since the zero run count last stood at or above the limit
    if (zero_nxt >= ZW'(ZRUN_LIMIT))  quiet_nxt = '0;
    else if (quiet_q == CW'(WIN))     quiet_nxt = quiet_q;
    else                              quiet_nxt = quiet_q + 1'b1;
    ok_nxt = (ones_nxt >= CW'(MIN_ONES)) && (quiet_nxt == CW'(WIN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      ones_q  <= '0;
      quiet_q <= '0;
    end else if (bit_en) begin
      hist_q  <= hist_nxt;
      ones_q  <= ones_nxt;
      quiet_q <= quiet_nxt;
    end
  end

  // R5: the running ones count matches the population of the history
  p_count_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q == CW'($countones(hist_q)));

  // R6: the quiet count never runs past the window length
  p_quiet_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_q <= CW'(WIN));
endmodule

// File: rtl/los_ctrl.sv
module los_ctrl
  import los_pkg::*;
#(
  parameter int T1_DECLARE   = 175,
  parameter int E1_DECLARE   = 32,
  parameter int LONG_DECLARE = 2048,
  parameter int MARK_RUN     = 32,
  parameter int ZW           = 12,
  parameter int OW           = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          e1_mode,
  input  logic          long_declare,
  input  logic          mark_clear,
  input  logic [ZW-1:0] zero_nxt,
  input  logic [OW-1:0] ones_nxt,
  input  logic          t1_ok,
  input  logic          e1_ok,
  output logic          los,
  output logic          los_change
);
  los_state_e    state_q, state_nxt;
  logic          chg_q, chg_nxt;
  logic [ZW-1:0] thr;
  logic          clr;

  always_comb begin
    if (long_declare) thr = ZW'(LONG_DECLARE);
    else if (e1_mode) thr = ZW'(E1_DECLARE);
    else              thr = ZW'(T1_DECLARE);

    if (!e1_mode)        clr = t1_ok;
    else if (mark_clear) clr = (ones_nxt >= OW'(MARK_RUN));
    else                 clr = e1_ok;

    state_nxt = state_q;
    if (bit_en) begin
      if (state_q == ST_LOST && clr)            state_nxt = ST_SIGNAL;
      else if (state_q == ST_SIGNAL && zero_nxt >= thr) state_nxt = ST_LOST;
    end
    chg_nxt = (state_nxt != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOST;
      chg_q   <= 1'b0;
    end else begin
      state_q <= state_nxt;
      chg_q   <= chg_nxt;
    end
  end

  assign los        = (state_q == ST_LOST);
  assign los_change = chg_q;

  // R3: a declaration only follows a zero run at the selected threshold
  p_declare_thr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> ($past(zero_nxt) >= $past(thr)));

  // R9: the change pulse marks a real change of LOS
  p_change_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    los_change |-> (los != $past(los)));

  // R10: without an accepted bit LOS holds and no pulse appears
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> ($stable(los) && !los_change));
endmodule

// File: rtl/los_monitor.sv
module los_monitor #(
  parameter int T1_DECLARE    = 175,
  parameter int E1_DECLARE    = 32,
  parameter int LONG_DECLARE  = 2048,
  parameter int T1_WIN        = 128,
  parameter int T1_MIN_ONES   = 16,
  parameter int T1_ZRUN_LIMIT = 100,
  parameter int E1_WIN        = 32,
  parameter int E1_MIN_ONES   = 4,
  parameter int E1_ZRUN_LIMIT = 16,
  parameter int MARK_RUN      = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic e1_mode,
  input  logic long_declare,
  input  logic mark_clear,
  output logic los,
  output logic use_master_clk,
  output logic los_change
);
  localparam int ZW = $clog2(LONG_DECLARE + 1);
  localparam int OW = $clog2(MARK_RUN + 1);

  logic          rst_sync_n;
  logic [ZW-1:0] zero_nxt;
  logic [OW-1:0] ones_nxt;
  logic          t1_ok, e1_ok;

  los_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  los_run_counter #(
    .ZERO_MAX (LONG_DECLARE),
    .ONES_MAX (MARK_RUN),
    .ZW       (ZW),
    .OW       (OW)
  ) i_runs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_en   (bit_en),
    .rx_bit   (rx_bit),
    .zero_nxt (zero_nxt),
    .ones_nxt (ones_nxt)
  );

  los_density_win #(
    .WIN        (T1_WIN),
    .MIN_ONES   (T1_MIN_ONES),
    .ZRUN_LIMIT (T1_ZRUN_LIMIT),
    .ZW         (ZW)
  ) i_t1_win (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_en   (bit_en),
    .rx_bit   (rx_bit),
    .zero_nxt (zero_nxt),
    .ok_nxt   (t1_ok)
  );

  los_density_win #(
    .WIN        (E1_WIN),
    .MIN_ONES   (E1_MIN_ONES),
    .ZRUN_LIMIT (E1_ZRUN_LIMIT),
    .ZW         (ZW)
  ) i_e1_win (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_en   (bit_en),
    .rx_bit   (rx_bit),
    .zero_nxt (zero_nxt),
    .ok_nxt   (e1_ok)
  );

  los_ctrl #(
    .T1_DECLARE   (T1_DECLARE),
    .E1_DECLARE   (E1_DECLARE),
    .LONG_DECLARE (LONG_DECLARE),
    .MARK_RUN     (MARK_RUN),
    .ZW           (ZW),
    .OW           (OW)
  ) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .bit_en       (bit_en),
    .e1_mode      (e1_mode),
    .long_declare (long_declare),
    .mark_clear   (mark_clear),
    .zero_nxt     (zero_nxt),
    .ones_nxt     (ones_nxt),
    .t1_ok        (t1_ok),
    .e1_ok        (e1_ok),
    .los          (los),
    .los_change   (los_change)
  );

  // R8: the master clock is selected exactly while LOS is asserted
  assign use_master_clk = los;
endmodule

// File: tb/test_los_monitor.sv
module test_los_monitor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, bit_en, rx_bit, e1_mode, long_declare, mark_clear;
  logic los, use_master_clk, los_change;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // reference model state
  bit m_hist [0:127];
  int m_zhist [0:127];
  int m_zc, m_or;
  bit m_los, m_chg;

  always #(CLK_PERIOD/2) clk = ~clk;

  los_monitor i_los_monitor (
    .clk            (clk),
    .rst_n          (rst_n),
    .bit_en         (bit_en),
    .rx_bit         (rx_bit),
    .e1_mode        (e1_mode),
    .long_declare   (long_declare),
    .mark_clear     (mark_clear),
    .los            (los),
    .use_master_clk (use_master_clk),
    .los_change     (los_change)
  );

  function automatic int win_ones(int w);
    int n = 0;
    for (int i = 0; i < w; i++) n += int'(m_hist[i]);
    return n;
  endfunction

  function automatic bit win_quiet(int w, int lim);
    for (int i = 0; i < w; i++) if (m_zhist[i] >= lim) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 128; i++) begin
      m_hist[i]  = 1'b0;
      m_zhist[i] = 1 << 20;   // no history yet
    end
    m_zc = 0; m_or = 0; m_los = 1'b1; m_chg = 1'b0;
  endtask

  task automatic model_bit(bit b);
    bit prev, clr;
    int thr;
    m_zc = b ? 0 : ((m_zc < 2048) ? m_zc + 1 : 2048);
    m_or = b ? ((m_or < 32) ? m_or + 1 : 32) : 0;
    for (int i = 127; i > 0; i--) begin
      m_hist[i]  = m_hist[i-1];
      m_zhist[i] = m_zhist[i-1];
    end
    m_hist[0]  = b;
    m_zhist[0] = m_zc;
    thr  = long_declare ? 2048 : (e1_mode ? 32 : 175);
    prev = m_los;
    if (m_los) begin
      if (!e1_mode)       clr = (win_ones(128) >= 16) && win_quiet(128, 100);
      else if (mark_clear) clr = (m_or >= 32);
      else                clr = (win_ones(32) >= 4) && win_quiet(32, 16);
      if (clr) m_los = 1'b0;
    end else if (m_zc >= thr) begin
      m_los = 1'b1;
    end
    m_chg = (prev != m_los);
  endtask

  task automatic compare(string tag);
    checks++;
    if (los !== m_los || use_master_clk !== m_los || los_change !== m_chg) begin
      errors++;
      $display("FAIL %s: los=%b sel=%b chg=%b, expected los=%b sel=%b chg=%b",
               tag, los, use_master_clk, los_change, m_los, m_los, m_chg);
    end
  endtask

  task automatic send(bit b, string tag);
    @(negedge clk);
    bit_en = 1'b1;
    rx_bit = b;
    @(posedge clk);
    model_bit(b);
    #1;
    compare(tag);
  endtask

  task automatic send_run(bit b, int n, string tag);
    for (int i = 0; i < n; i++) send(b, tag);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    bit_en = 1'b0;
    rx_bit = 1'($urandom);
    @(posedge clk);
    m_chg = 1'b0;
    #1;
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5125));
    rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0;
    e1_mode = 1'b0; long_declare = 1'b0; mark_clear = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 compare("R1");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 compare("R1");

    // T1: recovery needs a full window of history (R5)
    send_run(1'b1, 130, "R5");
    // T1 declare boundary: 174 zeros hold, the 175th declares (R2)
    send_run(1'b0, 174, "R2");
    send(1'b0, "R2");
    send_run(1'b1, 130, "R5");
    // sparse T1 pattern: one mark in eight
    for (int i = 0; i < 20; i++) begin
      send(1'b1, "R5");
      send_run(1'b0, 7, "R5");
    end

    // E1 declare boundary (R3) and density clear (R6)
    e1_mode = 1'b1;
    send_run(1'b1, 4, "R6");
    send_run(1'b0, 31, "R3");
    send(1'b0, "R3");
    send_run(1'b1, 40, "R6");
    // 15-zero gaps stay below the E1 run limit
    for (int i = 0; i < 6; i++) begin
      send(1'b1, "R6");
      send_run(1'b0, 15, "R6");
    end

    // extended threshold in E1 and in T1 (R4)
    send_run(1'b1, 40, "R4");
    long_declare = 1'b1;
    send_run(1'b0, 2047, "R4");
    send(1'b0, "R4");
    long_declare = 1'b0;
    send_run(1'b1, 40, "R4");
    e1_mode = 1'b0;
    send_run(1'b1, 130, "R4");
    long_declare = 1'b1;
    send_run(1'b0, 2048, "R4");
    long_declare = 1'b0;
    send_run(1'b1, 130, "R4");

    // idle cycles do not count zeros (R10)
    e1_mode = 1'b1;
    send_run(1'b0, 20, "R10");
    for (int i = 0; i < 15; i++) idle("R10");
    send_run(1'b0, 12, "R10");
    for (int i = 0; i < 5; i++) idle("R10");

    // E1 marks-run clear ignores density (R7)
    mark_clear = 1'b1;
    for (int i = 0; i < 40; i++) begin
      send(1'b1, "R7");
      send(1'b0, "R7");
    end
    send_run(1'b1, 31, "R7");
    send(1'b1, "R7");
    // in T1 the marks-run option is ignored (R7)
    e1_mode = 1'b0;
    send_run(1'b0, 175, "R7");
    for (int i = 0; i < 40; i++) begin
      send(1'b1, "R7");
      send_run(1'b0, 3, "R7");
    end

    // constrained random phases (R8, R9)
    for (int ph = 0; ph < 40; ph++) begin
      int lvl, per_mille, len;
      e1_mode      = 1'($urandom);
      mark_clear   = 1'($urandom);
      long_declare = ($urandom_range(0, 7) == 0);
      lvl = $urandom_range(0, 5);
      case (lvl)
        0: per_mille = 0;
        1: per_mille = 20;
        2: per_mille = 80;
        3: per_mille = 150;
        4: per_mille = 500;
        default: per_mille = 1000;
      endcase
      len = $urandom_range(50, 700);
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(0, 15) == 0) idle("R10");
        send(($urandom_range(0, 999) < per_mille), "R8/R9");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule